// File: doc/BRIEF.md
# Segment Memory Access Checker

This block decides whether one memory access through a segment register is legal, using the descriptor attributes cached for that register. Each cycle in which `in_valid` is high, the block takes an access (offset, byte count, kind) together with the cached descriptor state. One clock later it returns the verdict: pass or fault, a cause code for a fault, and the linear address the access maps to.

Three checks run in parallel.

- **Null check.** Flags a null selector in the 32-bit modes.
- **Type check.** Rejects writes to code or read-only data, reads of execute-only code, and fetches from data segments.
- **Limit check.** Scales the raw limit by granularity and tests the whole span of the access. The test runs against the range `[0, limit]` for a normal segment. For an expand-down segment it runs against `(limit, upper bound]`.

In 64-bit mode the limit check and the null check are bypassed. In that mode the base is forced to zero for every register except the two that keep a per-thread base.

Top module: `seg_access_checker`

## Requirements
- R1: The effective limit is the 20-bit raw limit when `desc_g` is 0. When `desc_g` is 1 it is `(raw << 12) | 0xFFF`.
- R2: For a normal segment (`desc_e` = 0) in a 32-bit mode, the last byte of the access must not exceed the effective limit, or the result is a limit fault. The last byte is `offset[31:0] + acc_bytes_m1`, computed without wrap.
- R3: For an expand-down segment (`desc_e` = 1) in a 32-bit mode, the first byte must be strictly above the effective limit. The last byte must be at or below the upper bound, which is 0xFFFF when `desc_db` is 0 and 0xFFFFFFFF when `desc_db` is 1. Otherwise the result is a limit fault.
- R4: A write (`acc_kind` = 1) faults with a type fault if the segment is code (`desc_type[3]` = 1) or is data with `desc_type[1]` = 0.
- R5: A read (`acc_kind` = 0 or 3) of code with `desc_type[1]` = 0 is a type fault. A fetch (`acc_kind` = 2) from a data segment (`desc_type[3]` = 0) is a type fault. Bits 0 and 2 of `desc_type` have no effect.
- R6: With `long_mode` = 0, an access whose `desc_is_null` is 1 is a null fault. With `long_mode` = 1, `desc_is_null` has no effect.
- R7: With `long_mode` = 1, no limit fault is ever reported, whatever the limit fields and the offset.
- R8: With `long_mode` = 0, the linear address is `(base[31:0] + offset[31:0]) mod 2^32`, zero-extended. With `long_mode` = 1 it is `base + offset` (mod 2^64) when `seg_sel` is 4 or 5. For every other `seg_sel` code (0 to 3, 6, 7) it is just `offset`.
- R9: `out_cause` encodes 0 = none, 1 = limit, 2 = type, 3 = null, with priority null > type > limit. `out_fault` is 1 exactly when `out_cause` is not 0.
- R10: `out_valid` equals `in_valid` of the previous cycle, and the other outputs belong to that access. A synchronous reset clears `out_valid`, `out_fault`, `out_cause` and `out_lin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Access present this cycle |
| offset | input | 64 | Effective offset of the access |
| acc_bytes_m1 | input | 3 | Access size in bytes minus one |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| long_mode | input | 1 | 1 = 64-bit mode |
| seg_sel | input | 3 | Segment register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| desc_base | input | 64 | Cached segment base |
| desc_limit | input | 20 | Cached raw limit |
| desc_g | input | 1 | Granularity flag |
| desc_e | input | 1 | Expand-down flag |
| desc_db | input | 1 | Default/big flag, picks the expand-down upper bound |
| desc_type | input | 4 | Bit 3 code, bit 1 readable (code) / writable (data) |
| desc_is_null | input | 1 | Register holds a null selector |
| out_valid | output | 1 | Result present |
| out_fault | output | 1 | Access faults |
| out_cause | output | 2 | Fault cause code |
| out_lin | output | 64 | Linear address |

## Verification
The bench sweeps offsets across a window around each effective limit and around the 64 KiB and 4 GiB bounds. It does this for every combination of granularity, direction and D/B, and for sizes of 1, 2, 4 and 8 bytes.

The sweep targets the following errors:

- **Last byte ignored.** A checker that tests only the first byte passes accesses that straddle the limit.
- **Wrong compare at the limit.** A checker that accepts the limit byte itself in an expand-down segment shows up at offset equal to the limit.
- **Wrong upper bound.** A checker that picks the wrong bound misjudges accesses near 0xFFFF.
- **Unscaled limit.** A checker that forgets the 0xFFF fill faults offsets just below a page-granular limit.
- **Overflow lost.** A checker that computes the last byte in 32 bits lets accesses near 4 GiB wrap into range.

All type/kind combinations are walked with and without a null selector in both modes, which catches a wrong cause priority. The 64-bit runs use tiny limits with huge offsets, and a base that must be dropped for four of the registers.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int VA_W       = 64;
    localparam int LEG_W      = 32;
    localparam int RAW_LIM_W  = 20;
    localparam int GRAN_SHIFT = 12;
    localparam int SMALL_UB_W = 16;
    localparam int SIZE_W     = 3;
    localparam int SEL_W      = 3;
    localparam int TYPE_W     = 4;
    localparam int TYPE_CODE_BIT = 3;
    localparam int TYPE_RW_BIT   = 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_kind_e;

    typedef enum logic [SEL_W-1:0] {
        SR_ES = 3'd0,
        SR_CS = 3'd1,
        SR_SS = 3'd2,
        SR_DS = 3'd3,
        SR_FS = 3'd4,
        SR_GS = 3'd5,
        SR_R6 = 3'd6,
        SR_R7 = 3'd7
    } seg_reg_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LIMIT = 2'd1,
        CAUSE_TYPE  = 2'd2,
        CAUSE_NULL  = 2'd3
    } cause_e;

    typedef struct packed {
        logic [VA_W-1:0]      base;
        logic [RAW_LIM_W-1:0] raw_limit;
        logic                 gran;
        logic                 exp_down;
        logic                 big;
        logic [TYPE_W-1:0]    typ;
        logic                 is_null;
    } desc_t;

    typedef struct packed {
        logic [VA_W-1:0]   off;
        logic [SIZE_W-1:0] bytes_m1;
        acc_kind_e         kind;
        logic              long_mode;
        seg_reg_e          sel;
    } acc_t;

    typedef struct packed {
        logic            fault;
        cause_e          cause;
        logic [VA_W-1:0] lin;
    } result_t;

    // Priority: null over type over limit.
    function automatic cause_e pick_cause(input logic null_bad,
                                          input logic type_bad,
                                          input logic limit_bad);
        cause_e c;
        if (null_bad)       c = CAUSE_NULL;
        else if (type_bad)  c = CAUSE_TYPE;
        else if (limit_bad) c = CAUSE_LIMIT;
        else                c = CAUSE_NONE;
        return c;
    endfunction

    function automatic logic keeps_base(input seg_reg_e s);
        return (s == SR_FS) || (s == SR_GS);
    endfunction

endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_chk_pkg::*;
#(
    parameter int LW  = LEG_W,
    parameter int RLW = RAW_LIM_W,
    parameter int GS  = GRAN_SHIFT,
    parameter int SUW = SMALL_UB_W,
    parameter int SZW = SIZE_W
) (
    input  logic [LW-1:0]  off,
    input  logic [SZW-1:0] bytes_m1,
    input  logic [RLW-1:0] raw_limit,
    input  logic           gran,
    input  logic           exp_down,
    input  logic           big,
    input  logic           long_mode,
    output logic           limit_bad
);
    localparam int LIM_W = RLW + GS;
    localparam int EXT_W = LW + 1;

    logic [LIM_W-1:0] eff_lim;
    logic [LW-1:0]    upper;
    logic [EXT_W-1:0] first_b, last_b, lim_x, upper_x;
    logic             normal_ok, down_ok;

    generate
        if (GS > 0) begin : g_scaled
            always_comb eff_lim = gran ? {raw_limit, {GS{1'b1}}}
                                       : {{GS{1'b0}}, raw_limit};
        end else begin : g_flat
            always_comb eff_lim = raw_limit;
        end
    endgenerate

    always_comb begin
        upper   = big ? {LW{1'b1}} : {{(LW-SUW){1'b0}}, {SUW{1'b1}}};
        first_b = EXT_W'(off);
        last_b  = first_b + EXT_W'(bytes_m1);
        lim_x   = EXT_W'(eff_lim);
        upper_x = EXT_W'(upper);
        normal_ok = (last_b <= lim_x);
        down_ok   = (first_b > lim_x) && (last_b <= upper_x);
        limit_bad = !long_mode && !(exp_down ? down_ok : normal_ok);
    end

endmodule

// File: rtl/seg_type_chk.sv
module seg_type_chk
    import seg_chk_pkg::*;
#(
    parameter int TW = TYPE_W
) (
    input  acc_kind_e      kind,
    input  logic [TW-1:0]  typ,
    output logic           type_bad
);
    logic is_code, rw;

    always_comb begin
        is_code = typ[TYPE_CODE_BIT];
        rw      = typ[TYPE_RW_BIT];
        unique case (kind)
            ACC_WRITE: type_bad = is_code || !rw;
            ACC_FETCH: type_bad = !is_code;
            default:   type_bad = is_code && !rw;
        endcase
    end

endmodule

// File: rtl/seg_lin_gen.sv
module seg_lin_gen
    import seg_chk_pkg::*;
#(
    parameter int VW  = VA_W,
    parameter int LW  = LEG_W,
    parameter int SW  = SEL_W
) (
    input  logic [VW-1:0] base,
    input  logic [VW-1:0] off,
    input  logic [SW-1:0] sel,
    input  logic          long_mode,
    output logic [VW-1:0] lin
);
    localparam int NCODES = 1 << SW;

    logic [NCODES-1:0] keep_tbl;
    logic [LW-1:0]     leg_sum;
    logic [VW-1:0]     eff_base;

    generate
        for (genvar i = 0; i < NCODES; i++) begin : g_keep
            assign keep_tbl[i] = keeps_base(seg_reg_e'(i));
        end
    endgenerate

    always_comb begin
        leg_sum  = base[LW-1:0] + off[LW-1:0];
        eff_base = keep_tbl[sel] ? base : '0;
        lin      = long_mode ? (eff_base + off) : VW'(leg_sum);
    end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int VW  = VA_W,
    parameter int LW  = LEG_W,
    parameter int RLW = RAW_LIM_W,
    parameter int GS  = GRAN_SHIFT,
    parameter int SUW = SMALL_UB_W,
    parameter int SZW = SIZE_W,
    parameter int SW  = SEL_W,
    parameter int TW  = TYPE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [VW-1:0]  offset,
    input  logic [SZW-1:0] acc_bytes_m1,
    input  logic [1:0]     acc_kind,
    input  logic           long_mode,
    input  logic [SW-1:0]  seg_sel,
    input  logic [VW-1:0]  desc_base,
    input  logic [RLW-1:0] desc_limit,
    input  logic           desc_g,
    input  logic           desc_e,
    input  logic           desc_db,
    input  logic [TW-1:0]  desc_type,
    input  logic           desc_is_null,
    output logic           out_valid,
    output logic           out_fault,
    output logic [1:0]     out_cause,
    output logic [VW-1:0]  out_lin
);
    desc_t   dsc;
    acc_t    acc;
    result_t res_d, res_q;
    logic    limit_bad, type_bad, null_bad;
    logic    valid_q;

    always_comb begin
        dsc.base      = desc_base;
        dsc.raw_limit = desc_limit;
        dsc.gran      = desc_g;
        dsc.exp_down  = desc_e;
        dsc.big       = desc_db;
        dsc.typ       = desc_type;
        dsc.is_null   = desc_is_null;
        acc.off       = offset;
        acc.bytes_m1  = acc_bytes_m1;
        acc.kind      = acc_kind_e'(acc_kind);
        acc.long_mode = long_mode;
        acc.sel       = seg_reg_e'(seg_sel);
    end

    seg_limit_chk #(.LW(LW), .RLW(RLW), .GS(GS), .SUW(SUW), .SZW(SZW)) u_limit (
        .off       (acc.off[LW-1:0]),
        .bytes_m1  (acc.bytes_m1),
        .raw_limit (dsc.raw_limit),
        .gran      (dsc.gran),
        .exp_down  (dsc.exp_down),
        .big       (dsc.big),
        .long_mode (acc.long_mode),
        .limit_bad (limit_bad)
    );

    seg_type_chk #(.TW(TW)) u_type (
        .kind     (acc.kind),
        .typ      (dsc.typ),
        .type_bad (type_bad)
    );

    seg_lin_gen #(.VW(VW), .LW(LW), .SW(SW)) u_lin (
        .base      (dsc.base),
        .off       (acc.off),
        .sel       (acc.sel),
        .long_mode (acc.long_mode),
        .lin       (res_d.lin)
    );

    always_comb begin
        null_bad    = dsc.is_null && !acc.long_mode;
        res_d.cause = pick_cause(null_bad, type_bad, limit_bad);
        res_d.fault = null_bad || type_bad || limit_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid = valid_q;
    assign out_fault = res_q.fault;
    assign out_cause = res_q.cause;
    assign out_lin   = res_q.lin;

    // R10: one-cycle result latency
    p_valid_latency_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R7: 64-bit mode never reports a limit fault
    p_long_no_limit_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && long_mode) |=> (out_cause != CAUSE_LIMIT));

    // R6: null selector in 32-bit modes wins
    p_null_legacy_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_mode && desc_is_null) |=> (out_fault && out_cause == CAUSE_NULL));

    // R4: writes to code segments give a type fault
    p_write_code_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_kind == 2'd1 && desc_type[TYPE_CODE_BIT]
         && !(desc_is_null && !long_mode)) |=> (out_cause == CAUSE_TYPE));

    // R8: flat registers drop the base in 64-bit mode
    p_flat_base_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && long_mode && seg_sel == SR_DS) |=> (out_lin == $past(offset)));

    // R9: fault flag agrees with the cause code
    p_fault_flag_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_fault == (out_cause != CAUSE_NONE)));

endmodule

// File: tb/seg_access_checker_tb_top.sv
module seg_access_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] offset;
    logic [2:0]  acc_bytes_m1;
    logic [1:0]  acc_kind;
    logic        long_mode;
    logic [2:0]  seg_sel;
    logic [63:0] desc_base;
    logic [19:0] desc_limit;
    logic        desc_g, desc_e, desc_db;
    logic [3:0]  desc_type;
    logic        desc_is_null;
    logic        out_valid, out_fault;
    logic [1:0]  out_cause;
    logic [63:0] out_lin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    seg_access_checker dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .offset(offset),
        .acc_bytes_m1(acc_bytes_m1), .acc_kind(acc_kind), .long_mode(long_mode),
        .seg_sel(seg_sel), .desc_base(desc_base), .desc_limit(desc_limit),
        .desc_g(desc_g), .desc_e(desc_e), .desc_db(desc_db), .desc_type(desc_type),
        .desc_is_null(desc_is_null), .out_valid(out_valid), .out_fault(out_fault),
        .out_cause(out_cause), .out_lin(out_lin)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Expected cause from the requirements (R1..R7, R9)
    function automatic logic [1:0] exp_cause(
        input logic [31:0] off, input int nb_m1, input logic [1:0] kind,
        input logic lm, input logic [19:0] raw, input logic g, input logic e,
        input logic db, input logic [3:0] typ, input logic nul);
        longint eff, ub, first, last;
        logic tbad, lbad;
        eff   = g ? ((longint'(raw) * 4096) + 4095) : longint'(raw);
        ub    = db ? 64'hFFFF_FFFF : 64'hFFFF;
        first = longint'(off);
        last  = first + nb_m1;
        if (kind == 2'd1)      tbad = typ[3] || !typ[1];
        else if (kind == 2'd2) tbad = !typ[3];
        else                   tbad = typ[3] && !typ[1];
        if (lm) lbad = 0;
        else if (e) lbad = !((first > eff) && (last <= ub));
        else        lbad = !(last <= eff);
        if (nul && !lm) return 2'd3;
        if (tbad)       return 2'd2;
        if (lbad)       return 2'd1;
        return 2'd0;
    endfunction

    // Drive at negedge; the result registers on the next posedge and is sampled at the next negedge.
    task automatic access(input string req, input logic [63:0] off, input int nb_m1,
                          input logic [1:0] kind, input logic lm, input logic [2:0] sel,
                          input logic [63:0] base, input logic [19:0] raw, input logic g,
                          input logic e, input logic db, input logic [3:0] typ,
                          input logic nul, input logic [63:0] exp_lin, input bit chk_lin);
        logic [1:0] ec;
        in_valid = 1; offset = off; acc_bytes_m1 = 3'(nb_m1); acc_kind = kind;
        long_mode = lm; seg_sel = sel; desc_base = base; desc_limit = raw;
        desc_g = g; desc_e = e; desc_db = db; desc_type = typ; desc_is_null = nul;
        ec = exp_cause(off[31:0], nb_m1, kind, lm, raw, g, e, db, typ, nul);
        @(negedge clk);
        in_valid = 0;
        check({req, " valid R10"}, 64'(out_valid), 64'd1);
        check({req, " cause R9"}, 64'(out_cause), 64'(ec));
        check({req, " fault R9"}, 64'(out_fault), 64'(ec != 2'd0));
        if (chk_lin) check({req, " lin R8"}, out_lin, exp_lin);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [19:0] raws [5];
        int          sizes [4];
        raws[0] = 20'h0; raws[1] = 20'h5; raws[2] = 20'hFFFE;
        raws[3] = 20'hFFFF; raws[4] = 20'hFFFFF;
        sizes[0] = 0; sizes[1] = 1; sizes[2] = 3; sizes[3] = 7;
        rst = 1; in_valid = 0; offset = 0; acc_bytes_m1 = 0; acc_kind = 0;
        long_mode = 0; seg_sel = 0; desc_base = 0; desc_limit = 0; desc_g = 0;
        desc_e = 0; desc_db = 0; desc_type = 0; desc_is_null = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("reset R10 valid", 64'(out_valid), 64'd0);
        check("reset R10 fault", 64'(out_fault), 64'd0);
        check("reset R10 cause", 64'(out_cause), 64'd0);
        check("reset R10 lin", out_lin, 64'd0);
        rst = 0;
        @(negedge clk);
        check("idle R10 valid", 64'(out_valid), 64'd0);

        // R1 R2 R3: limit sweep, writable data segment, 32-bit mode
        for (int g = 0; g < 2; g++)
            for (int e = 0; e < 2; e++)
                for (int db = 0; db < 2; db++)
                    for (int ri = 0; ri < 5; ri++)
                        for (int si = 0; si < 4; si++) begin
                            longint eff;
                            logic [31:0] offs [16];
                            eff = g ? (longint'(raws[ri]) * 4096 + 4095) : longint'(raws[ri]);
                            for (int d = 0; d < 11; d++) offs[d] = 32'(eff + d - 8);
                            offs[11] = 32'h0;        offs[12] = 32'hFFFC;
                            offs[13] = 32'hFFFF;     offs[14] = 32'h1_0000;
                            offs[15] = 32'hFFFF_FFFC;
                            for (int oi = 0; oi < 16; oi++)
                                access("R1 R2 R3 limit sweep", {32'hDEAD_BEEF, offs[oi]},
                                       sizes[si], 2'd0, 1'b0, 3'd3, 64'h1234_5678_1000_0000,
                                       raws[ri], g[0], e[0], db[0], 4'b0010, 1'b0,
                                       {32'h0, 32'(32'h1000_0000 + offs[oi])}, 1);
                        end

        // R4 R5 R6 R9: all types and kinds, null and not, both modes
        for (int lm = 0; lm < 2; lm++)
            for (int nul = 0; nul < 2; nul++)
                for (int t = 0; t < 16; t++)
                    for (int k = 0; k < 4; k++)
                        access("R4 R5 R6 type walk", 64'h10, 1, 2'(k), lm[0], 3'd0,
                               64'h0, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 4'(t), nul[0], 64'h10, 1);

        // R9 priority with a limit fault present too
        access("R9 type over limit", 64'h100, 0, 2'd1, 1'b0, 3'd3, 64'h0, 20'h10,
               1'b0, 1'b0, 1'b0, 4'b1010, 1'b0, 64'h100, 1);
        access("R9 null over all", 64'h100, 0, 2'd1, 1'b0, 3'd3, 64'h0, 20'h10,
               1'b0, 1'b0, 1'b0, 4'b1010, 1'b1, 64'h100, 1);

        // R7 R8: 64-bit mode, tiny limit, huge offsets, every register code
        for (int s = 0; s < 8; s++)
            for (int e = 0; e < 2; e++) begin
                logic [63:0] base, off, lin;
                base = 64'hFFFF_0000_1234_0000;
                off  = 64'h0000_7FFF_FFFF_FFF8 + 64'(s);
                lin  = (s == 4 || s == 5) ? base + off : off;
                access("R7 R8 long mode", off, 7, 2'd0, 1'b1, 3'(s), base, 20'h0,
                       1'b0, e[0], 1'b0, 4'b0010, 1'b1, lin, 1);
            end

        // R8: 32-bit wrap of linear address
        access("R8 legacy wrap", 64'h0000_0000_FFFF_F000, 0, 2'd0, 1'b0, 3'd4,
               64'h0000_0001_0000_2000, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 4'b0010, 1'b0,
               64'h0000_0000_0000_1000, 1);

        // R10: back-to-back accesses then idle
        @(negedge clk);
        check("R10 idle after burst", 64'(out_valid), 64'd0);
        finish_run();
    end
endmodule